// File: doc/BRIEF.md
# Supply Level Sequencer with Readback Check

This block drives one change of the processor supply level. A client offers a 3-bit logical level on a valid strobe. While idle, the block takes the request. It maps the logical level onto the regulator's level code and issues a single write of a request word on its register port. It then waits a settle time, counted in clock cycles and taken from a configuration input when the request is accepted.

When the wait ends, the block samples the level that the regulator reports on its status input and compares it with the code it requested. It then pulses `done`. It raises `err` in the same cycle when the reported level does not match the request.

The regulator itself is outside the block. A client treats `err` as an I/O failure of the supply change. A request offered while a change is already under way is dropped.

Top module: `vdd_level_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `reg_wr_en` are all low.
- R2: A request accepted at a clock edge makes `reg_wr_en` high for exactly the following cycle. In that cycle `reg_wr_data` has bit 7 set to 1, bits [5:3] holding the level code, and bits 6 and [2:0] at 0.
- R3: The level code equals the logical level for levels 0, 1, 2 and 7. Logical levels 3, 4, 5 and 6 all map to code 3.
- R4: With a settle count N, `done` is high exactly N+1 cycles after the cycle in which `reg_wr_en` is high. `status_level` is sampled at the clock edge that raises `done`, so a status change that appears later is not seen.
- R5: If the sampled status equals the level code, `done` is raised with `err` low.
- R6: If the sampled status differs from the level code, `err` is high in the same cycle as `done`, and only then.
- R7: `done` is a single-cycle pulse, and there is exactly one pulse per accepted request.
- R8: A request offered while `busy` is high produces no register write and no extra `done`. It also does not change the level that is written or checked.
- R9: With a settle count of 0, `done` follows the write cycle directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_level | input | 3 | Logical supply level requested |
| settle_cycles | input | CNT_W | Settle wait in clock cycles, latched on acceptance |
| status_level | input | 3 | Level code reported by the regulator |
| reg_wr_en | output | 1 | Write strobe for the supply-level register |
| reg_wr_data | output | 8 | Request word written to the register |
| busy | output | 1 | A change is under way |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Readback mismatch, valid with `done` |

## Verification
The hardest case to reach is a regulator that does reach the requested level, but later than the sample point. The result then depends on the exact edge at which the block samples the status.

The bench models the regulator with a programmable lag after the write. It runs a settle count of 6 with lags one apart on either side of the sample edge. The earlier lag must report success and the later one must report an error.

Before the late run, the status is first left at a different level. This guarantees that a stale readback cannot pass by accident.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_SETTLE = 1'b1
  } vls_state_t;
endpackage

// File: rtl/vls_level_encoder.sv
module vls_level_encoder #(
  parameter int LVL_W   = 3,
  parameter int CLAMP_LO = 3,
  parameter int CLAMP_HI = 6
) (
  input  logic [LVL_W-1:0] level_i,
  output logic [LVL_W-1:0] code_o
);
  always_comb begin
    if ((int'(level_i) >= CLAMP_LO) && (int'(level_i) <= CLAMP_HI))
      code_o = LVL_W'(CLAMP_LO);
    else
      code_o = level_i;
  end
endmodule

// File: rtl/vls_settle_timer.sv
module vls_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= load_val_i;
    else if (run_i && (cnt_q != '0))
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R4: the wait shortens by one each running cycle
  a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
    (run_i && !load_i && !expired_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/vdd_level_sequencer.sv
module vdd_level_sequencer
  import vls_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int LVL_W    = 3,
  parameter int WORD_W   = 8,
  parameter int FLAG_BIT = 7,
  parameter int LVL_LSB  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LVL_W-1:0]  req_level,
  input  logic [CNT_W-1:0]  settle_cycles,
  input  logic [LVL_W-1:0]  status_level,
  output logic              reg_wr_en,
  output logic [WORD_W-1:0] reg_wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int LVL_MSB = LVL_LSB + LVL_W - 1;

  vls_state_t       state_q;
  logic [LVL_W-1:0] enc_code;
  logic [LVL_W-1:0] code_q;
  logic [WORD_W-1:0] word_n;
  logic             accept;
  logic             expired;

  vls_level_encoder #(.LVL_W(LVL_W)) u_enc (
    .level_i (req_level),
    .code_o  (enc_code)
  );

  vls_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept),
    .load_val_i (settle_cycles),
    .run_i      (state_q == ST_SETTLE),
    .expired_o  (expired)
  );

  assign accept = req_valid && (state_q == ST_IDLE);
  assign busy   = (state_q != ST_IDLE);

  always_comb begin
    word_n = '0;
    word_n[FLAG_BIT] = 1'b1;
    word_n[LVL_LSB +: LVL_W] = enc_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      code_q      <= '0;
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            code_q      <= enc_code;
            reg_wr_en   <= 1'b1;
            reg_wr_data <= word_n;
            state_q     <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (expired) begin
            done    <= 1'b1;
            err     <= (status_level != code_q);
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: request word shape whenever the register is written
  a_r2_word_form: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> (reg_wr_data[FLAG_BIT] && (reg_wr_data[LVL_LSB-1:0] == '0)
                   && (reg_wr_data[WORD_W-1:LVL_MSB+1] & ~(WORD_W-LVL_MSB-1)'(1 << (FLAG_BIT-LVL_MSB-1))) == '0));
  // R2: write strobe lasts one cycle
  a_r2_wr_single: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);
  // R7: done is a one-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: error only alongside done
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  // R8: an accepted request makes the block busy and writes next cycle
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> (busy && reg_wr_en));
  // R8: no write while already busy
  a_r8_no_write_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !reg_wr_en);
endmodule

// File: tb/vdd_level_sequencer_tb_top.sv
`timescale 1ns/1ps
module vdd_level_sequencer_tb_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [2:0]       req_level = '0;
  logic [CNT_W-1:0] settle_cycles = '0;
  logic [2:0]       status_level;
  logic             reg_wr_en;
  logic [7:0]       reg_wr_data;
  logic             busy, done, err;

  int n_chk = 0;
  int n_fail = 0;

  // regulator model
  int         reg_lag = 0;
  bit         reg_bad = 1'b0;
  logic       pend;
  int         rcnt;
  logic [2:0] tgt;

  always #2.5 clk = ~clk;

  vdd_level_sequencer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
    .settle_cycles(settle_cycles), .status_level(status_level),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .busy(busy), .done(done), .err(err)
  );

  always @(posedge clk) begin
    if (rst) begin
      status_level <= '0;
      pend <= 1'b0;
      rcnt <= 0;
      tgt  <= '0;
    end else if (reg_wr_en) begin
      pend <= 1'b1;
      rcnt <= reg_lag;
      tgt  <= reg_bad ? (reg_wr_data[5:3] ^ 3'b001) : reg_wr_data[5:3];
    end else if (pend) begin
      if (rcnt == 0) begin
        status_level <= tgt;
        pend <= 1'b0;
      end else begin
        rcnt <= rcnt - 1;
      end
    end
  end

  function automatic logic [2:0] exp_code(input logic [2:0] l);
    return (l >= 3 && l <= 6) ? 3'd3 : l;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one request, with an optional second request poked while busy
  task automatic run_req(input logic [2:0] lvl, input int n, input int lag, input bit bad,
                         input bit poke,
                         output int wr_at, output int done_at, output logic [7:0] word,
                         output logic errv, output int nwr, output int ndone);
    wr_at = -1; done_at = -1; word = '0; errv = 1'b0; nwr = 0; ndone = 0;
    @(negedge clk);
    reg_lag = lag; reg_bad = bad;
    req_valid = 1'b1; req_level = lvl; settle_cycles = CNT_W'(n);
    for (int k = 1; k <= n + 12; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (poke && k == 2) begin req_valid = 1'b1; req_level = lvl ^ 3'b100; settle_cycles = '0; end
      if (poke && k == 3) req_valid = 1'b0;
      if (reg_wr_en) begin nwr++; wr_at = k; word = reg_wr_data; end
      if (done) begin ndone++; done_at = k; errv = err; end
    end
  endtask

  task automatic t_reset;
    check(!busy && !done && !err && !reg_wr_en, "R1 reset outputs", {busy, done, err, reg_wr_en}, 0);
  endtask

  task automatic t_levels;
    int wa, da, nw, nd; logic [7:0] w; logic e;
    for (int l = 0; l < 8; l++) begin
      run_req(3'(l), 3, 0, 1'b0, 1'b0, wa, da, w, e, nw, nd);
      check(nw == 1, "R2 single write", nw, 1);
      check(w == (8'h80 | {2'b00, exp_code(3'(l)), 3'b000}), "R2/R3 request word", w,
            8'h80 | {2'b00, exp_code(3'(l)), 3'b000});
      check(da - wa == 4, "R4 settle timing", da - wa, 4);
      check(e == 1'b0, "R5 success", e, 0);
      check(nd == 1, "R7 one done pulse", nd, 1);
    end
  endtask

  task automatic t_mismatch;
    int wa, da, nw, nd; logic [7:0] w; logic e;
    run_req(3'd2, 4, 0, 1'b1, 1'b0, wa, da, w, e, nw, nd);
    check(e == 1'b1, "R6 mismatch error", e, 1);
    check(nd == 1, "R7 one done on error", nd, 1);
    run_req(3'd1, 2, 0, 1'b0, 1'b0, wa, da, w, e, nw, nd);
    check(e == 1'b0, "R6 error clears on next good change", e, 0);
  endtask

  task automatic t_late;
    int wa, da, nw, nd; logic [7:0] w; logic e;
    run_req(3'd0, 2, 0, 1'b0, 1'b0, wa, da, w, e, nw, nd);
    run_req(3'd7, 6, 4, 1'b0, 1'b0, wa, da, w, e, nw, nd);
    check(e == 1'b0, "R4 status settles before sample", e, 0);
    run_req(3'd0, 2, 0, 1'b0, 1'b0, wa, da, w, e, nw, nd);
    run_req(3'd7, 6, 5, 1'b0, 1'b0, wa, da, w, e, nw, nd);
    check(e == 1'b1, "R4 status after sample edge unseen", e, 1);
  endtask

  task automatic t_zero;
    int wa, da, nw, nd; logic [7:0] w; logic e;
    run_req(3'd5, 0, 0, 1'b1, 1'b0, wa, da, w, e, nw, nd);
    check(da - wa == 1, "R9 zero settle", da - wa, 1);
    check(e == 1'b1, "R9 zero settle samples old status", e, 1);
  endtask

  task automatic t_busy;
    int wa, da, nw, nd; logic [7:0] w; logic e;
    run_req(3'd1, 5, 0, 1'b0, 1'b1, wa, da, w, e, nw, nd);
    check(nw == 1, "R8 no write while busy", nw, 1);
    check(nd == 1, "R8 no extra done", nd, 1);
    check(w == 8'h88, "R8 word unchanged", w, 8'h88);
    check(da - wa == 6, "R8 timing unchanged", da - wa, 6);
    check(e == 1'b0, "R8 check uses first level", e, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_levels();
    t_mismatch();
    t_late();
    t_zero();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule